// File: doc/BRIEF.md
# PCI Target Parity Generator and Error Reporter

This block sits beside a PCI target sequencer and owns everything that has to do with bus parity. Every clock it folds the observed AD and C/BE# lines into one even-parity bit and keeps that bit for one cycle. When the previous cycle was a read data phase driven by the target, the stored bit is put on PAR. When the previous cycle was an address phase or a completed write data phase, the stored bit is compared with the PAR value that the initiator presents now.

A data parity mismatch drives PERR# low two clocks after the data phase, if the command register allows parity error response. PERR# is a sustained tri-state signal, so after its last low clock the block drives it high for one clock and then releases it. An address parity mismatch pulls the open-drain SERR# line low for one clock, if both the SERR enable bit and the parity response bit are set. Two sticky status flags record detected parity errors and signalled system errors. Software clears them by writing 1.

Top module: `pci_par_err_unit`

## Requirements
- R1: `par_oe` is 1 in exactly the cycles that follow a cycle with `rd_data_phase`=1. In such a cycle `par_out` makes the count of ones in {AD, C/BE#, PAR} even, using the AD and C/BE# values of the previous cycle.
- R2: A cycle with `wr_data_done`=1 is checked against the `par_in` of the next cycle. If the two differ and `perr_resp_en`=1, PERR# is driven low (`perr_oe`=1, `perr_n_out`=0) in the cycle two clocks after the data phase.
- R3: When `perr_resp_en`=0, a data parity error never drives PERR#. The detected-error flag is still set.
- R4: Each erroneous data phase gives one low PERR# clock. Back-to-back erroneous phases keep PERR# low over consecutive clocks.
- R5: After its last low clock, PERR# is driven high (`perr_oe`=1, `perr_n_out`=1) for exactly one clock and is then floated (`perr_oe`=0).
- R6: A cycle with `addr_phase`=1 is checked against the next cycle's `par_in`. On a mismatch with `serr_en`=1 and `perr_resp_en`=1, `serr_oe` (pull SERR# low) is 1 for one clock, two clocks after the address phase. In all other cases `serr_oe` stays 0, and SERR# is never driven high.
- R7: `sts_flags[0]` (detected parity error) becomes 1 one clock after any address or data parity mismatch is detected, whatever the enable bits are.
- R8: `sts_flags[1]` (signalled system error) becomes 1 in the same cycle that `serr_oe` first shows 1.
- R9: `sts_clr[i]`=1 clears `sts_flags[i]` on the next clock. A set event in the same cycle wins over the clear. `sts_clr[i]`=0 has no effect.
- R10: A `par_in` value that follows a cycle with neither `addr_phase` nor `wr_data_done` is ignored. It leaves PERR#, SERR# and the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_bus | input | 32 | Observed AD lines |
| cbe_bus_n | input | 4 | Observed C/BE# lines |
| par_in | input | 1 | Observed PAR line |
| addr_phase | input | 1 | This cycle is an address phase for this target |
| wr_data_done | input | 1 | This cycle completes a write data phase |
| rd_data_phase | input | 1 | This cycle the target drives read data on AD |
| perr_resp_en | input | 1 | Parity error response bit of the command register |
| serr_en | input | 1 | SERR enable bit of the command register |
| sts_clr | input | 2 | Write-1-to-clear strobes for the status flags |
| par_out | output | 1 | Generated PAR value |
| par_oe | output | 1 | Drive enable for PAR |
| perr_n_out | output | 1 | PERR# level when driven |
| perr_oe | output | 1 | Drive enable for PERR# |
| serr_oe | output | 1 | Pull SERR# low (open drain) |
| sts_flags | output | 2 | [0] detected parity error, [1] signalled system error |

## Verification
The assertions check on every cycle that any PERR# low clock or SERR# pulse was caused by a mismatch one clock earlier with the needed enables set. They also check that a low PERR# is always followed by a driven clock, that a high drive is followed by release or a new error, that driven PAR matches the previous cycle's bus, and that a detected error sets the status flag. The assertions cannot show that a mismatch outside a checked cycle is ignored, that the clear strobes behave as write-1-to-clear, or that generation is correct across many bit patterns. The bench scenarios cover these with swept data patterns and every combination of the enable bits.

// File: rtl/pci_pe_pkg.sv
package pci_pe_pkg;

  localparam int unsigned PAR_MAX_W = 64;

  typedef struct packed {
    logic addr;
    logic data;
  } par_evt_t;

  // Even parity bit: XOR of all covered lines (zero padded).
  function automatic logic even_par(input logic [PAR_MAX_W-1:0] bits);
    return ^bits;
  endfunction

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_bus,
  input  logic [CBE_W-1:0] cbe_bus_n,
  input  logic             rd_data_phase,
  output logic             par_prev,
  output logic             par_out,
  output logic             par_oe
);
  import pci_pe_pkg::*;

  localparam int unsigned COV_W = AD_W + CBE_W;

  logic [PAR_MAX_W-1:0] cov_bits;
  logic                 par_q;
  logic                 drive_q;

  assign cov_bits = PAR_MAX_W'({cbe_bus_n, ad_bus});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      par_q   <= even_par(cov_bits);
      drive_q <= rd_data_phase;
    end
  end

  assign par_prev = par_q;
  assign par_out  = par_q;
  assign par_oe   = drive_q;

  initial begin
    if (COV_W > PAR_MAX_W) $error("covered width too large");
  end
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_phase,
  input  logic                  wr_data_done,
  input  logic                  par_in,
  input  logic                  par_prev,
  output pci_pe_pkg::par_evt_t  evt
);
  logic addr_q;
  logic data_q;
  logic mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 1'b0;
      data_q <= 1'b0;
    end else begin
      addr_q <= addr_phase;
      data_q <= wr_data_done;
    end
  end

  assign mismatch = par_in ^ par_prev;
  assign evt.addr = addr_q & mismatch;
  assign evt.data = data_q & mismatch;
endmodule

// File: rtl/pci_err_report.sv
module pci_err_report (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pci_pe_pkg::par_evt_t evt,
  input  logic                 perr_resp_en,
  input  logic                 serr_en,
  input  logic [1:0]           sts_clr,
  output logic                 perr_n_out,
  output logic                 perr_oe,
  output logic                 serr_oe,
  output logic [1:0]           sts_flags
);
  logic perr_fire;
  logic serr_fire;
  logic perr_low_q;
  logic perr_high_q;
  logic serr_q;
  logic [1:0] sts_q;
  logic [1:0] sts_set;

  assign perr_fire = evt.data & perr_resp_en;
  assign serr_fire = evt.addr & perr_resp_en & serr_en;
  assign sts_set   = {serr_fire, evt.addr | evt.data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_low_q  <= 1'b0;
      perr_high_q <= 1'b0;
      serr_q      <= 1'b0;
      sts_q       <= '0;
    end else begin
      if (perr_fire) begin
        perr_low_q  <= 1'b1;
        perr_high_q <= 1'b0;
      end else begin
        perr_low_q  <= 1'b0;
        perr_high_q <= perr_low_q;
      end
      serr_q <= serr_fire;
      sts_q  <= sts_set | (sts_q & ~sts_clr);
    end
  end

  assign perr_oe    = perr_low_q | perr_high_q;
  assign perr_n_out = ~perr_low_q;
  assign serr_oe    = serr_q;
  assign sts_flags  = sts_q;
endmodule

// File: rtl/pci_par_err_unit.sv
module pci_par_err_unit #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_bus,
  input  logic [CBE_W-1:0] cbe_bus_n,
  input  logic             par_in,
  input  logic             addr_phase,
  input  logic             wr_data_done,
  input  logic             rd_data_phase,
  input  logic             perr_resp_en,
  input  logic             serr_en,
  input  logic [1:0]       sts_clr,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr_n_out,
  output logic             perr_oe,
  output logic             serr_oe,
  output logic [1:0]       sts_flags
);
  pci_pe_pkg::par_evt_t evt;
  logic par_prev;
  logic evt_addr;
  logic evt_data;

  assign evt_addr = evt.addr;
  assign evt_data = evt.data;

  pci_par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) gen_i (
    .clk(clk), .rst_n(rst_n), .ad_bus(ad_bus), .cbe_bus_n(cbe_bus_n),
    .rd_data_phase(rd_data_phase), .par_prev(par_prev),
    .par_out(par_out), .par_oe(par_oe)
  );

  pci_par_check chk_i (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase),
    .wr_data_done(wr_data_done), .par_in(par_in),
    .par_prev(par_prev), .evt(evt)
  );

  pci_err_report rep_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .perr_resp_en(perr_resp_en),
    .serr_en(serr_en), .sts_clr(sts_clr), .perr_n_out(perr_n_out),
    .perr_oe(perr_oe), .serr_oe(serr_oe), .sts_flags(sts_flags)
  );
endmodule

// File: rtl/pci_par_err_chk.sv
module pci_par_err_chk #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad_bus,
  input logic [CBE_W-1:0] cbe_bus_n,
  input logic             rd_data_phase,
  input logic             perr_resp_en,
  input logic             serr_en,
  input logic             par_out,
  input logic             par_oe,
  input logic             perr_n_out,
  input logic             perr_oe,
  input logic             serr_oe,
  input logic [1:0]       sts_flags,
  input logic             evt_addr,
  input logic             evt_data
);
  assert_par_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (par_out == ^{$past(cbe_bus_n), $past(ad_bus)}));

  assert_par_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_phase |=> par_oe);

  assert_perr_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_data && perr_resp_en) |=> (perr_oe && !perr_n_out));

  assert_perr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |-> $past(evt_data && perr_resp_en));

  assert_perr_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |=> perr_oe);

  assert_perr_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_out) |=> (!perr_oe || !perr_n_out));

  assert_serr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(evt_addr && serr_en && perr_resp_en));

  assert_sts_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_addr || evt_data) |=> sts_flags[0]);

  assert_sts_serr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> sts_flags[1]);
endmodule

bind pci_par_err_unit pci_par_err_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) chk_bind_i (
  .clk(clk), .rst_n(rst_n), .ad_bus(ad_bus), .cbe_bus_n(cbe_bus_n),
  .rd_data_phase(rd_data_phase), .perr_resp_en(perr_resp_en),
  .serr_en(serr_en), .par_out(par_out), .par_oe(par_oe),
  .perr_n_out(perr_n_out), .perr_oe(perr_oe), .serr_oe(serr_oe),
  .sts_flags(sts_flags), .evt_addr(evt_addr), .evt_data(evt_data)
);

// File: tb/pci_par_err_unit_tb_top.sv
module pci_par_err_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_bus = '0;
  logic [3:0]  cbe_bus_n = '0;
  logic        par_in = 1'b0;
  logic        addr_phase = 1'b0;
  logic        wr_data_done = 1'b0;
  logic        rd_data_phase = 1'b0;
  logic        perr_resp_en = 1'b0;
  logic        serr_en = 1'b0;
  logic [1:0]  sts_clr = '0;
  logic        par_out, par_oe, perr_n_out, perr_oe, serr_oe;
  logic [1:0]  sts_flags;

  int n_total = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pci_par_err_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ad_bus(ad_bus), .cbe_bus_n(cbe_bus_n),
    .par_in(par_in), .addr_phase(addr_phase), .wr_data_done(wr_data_done),
    .rd_data_phase(rd_data_phase), .perr_resp_en(perr_resp_en),
    .serr_en(serr_en), .sts_clr(sts_clr), .par_out(par_out),
    .par_oe(par_oe), .perr_n_out(perr_n_out), .perr_oe(perr_oe),
    .serr_oe(serr_oe), .sts_flags(sts_flags)
  );

  // PAR that makes the ones count of the 36 lines plus PAR even.
  function automatic logic model_par(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return (ones % 2) == 1;
  endfunction

  function automatic logic [31:0] pat_ad(input int k);
    return (32'h1 << (k % 32)) ^ (32'(k) * 32'h9E37_79B9);
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    addr_phase = 0; wr_data_done = 0; rd_data_phase = 0;
    par_in = 0; sts_clr = '0;
  endtask

  // One checked phase (address if is_addr) with optional bad PAR.
  task automatic phase_case(input logic is_addr, input logic resp,
                            input logic sen, input logic bad, input int k);
    logic p;
    logic exp_perr, exp_serr;
    perr_resp_en = resp; serr_en = sen;
    @(negedge clk);
    ad_bus = pat_ad(k); cbe_bus_n = 4'(k);
    p = model_par(ad_bus, cbe_bus_n);
    addr_phase = is_addr; wr_data_done = !is_addr;
    @(negedge clk);
    idle();
    par_in = p ^ bad;
    ad_bus = ~ad_bus;
    exp_perr = !is_addr && bad && resp;
    exp_serr = is_addr && bad && resp && sen;
    @(negedge clk);
    par_in = 0;
    check(perr_oe == exp_perr && (perr_n_out == !exp_perr || !perr_oe),
          is_addr ? "R6 no perr on addr" : (resp ? "R2 perr low" : "R3 perr gated"),
          {perr_oe, perr_n_out}, {exp_perr, !exp_perr});
    check(serr_oe == exp_serr, is_addr ? "R6 serr pulse" : "R6 no serr on data",
          serr_oe, exp_serr);
    check(sts_flags == {exp_serr, bad}, "R7 R8 status", sts_flags, {exp_serr, bad});
    @(negedge clk);
    check(perr_oe == exp_perr && perr_n_out == 1'b1, "R5 high one clock",
          {perr_oe, perr_n_out}, {exp_perr, 1'b1});
    check(serr_oe == 1'b0, "R6 serr one clock", serr_oe, 0);
    @(negedge clk);
    check(perr_oe == 1'b0, "R5 float", perr_oe, 0);
    sts_clr = 2'b11;
    @(negedge clk);
    sts_clr = 2'b00;
    check(sts_flags == 2'b00, "R9 clear", sts_flags, 0);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_total++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] a_prev;
    logic [3:0]  c_prev;
    repeat (3) @(negedge clk);
    check(par_oe == 0 && perr_oe == 0 && serr_oe == 0 && sts_flags == 0,
          "R1 reset state", {par_oe, perr_oe, serr_oe, sts_flags}, 0);
    rst_n = 1;

    // R1 sweep: consecutive read data phases over many patterns
    @(negedge clk);
    rd_data_phase = 1;
    ad_bus = pat_ad(0); cbe_bus_n = 4'(0);
    for (int k = 1; k <= 48; k++) begin
      a_prev = ad_bus; c_prev = cbe_bus_n;
      @(negedge clk);
      check(par_oe == 1 && par_out == model_par(a_prev, c_prev), "R1 par gen",
            {par_oe, par_out}, {1'b1, model_par(a_prev, c_prev)});
      ad_bus = pat_ad(k); cbe_bus_n = 4'(k);
      if (k == 48) rd_data_phase = 0;
    end
    @(negedge clk);
    @(negedge clk);
    check(par_oe == 0, "R1 par released", par_oe, 0);

    // Data and address phases over every enable combination
    for (int e = 0; e < 4; e++)
      for (int b = 0; b < 2; b++)
        for (int ph = 0; ph < 2; ph++)
          phase_case(ph[0], e[0], e[1], b[0], e * 4 + b * 2 + ph + 3);

    // R4: two back-to-back erroneous write data phases
    perr_resp_en = 1; serr_en = 0;
    @(negedge clk);
    ad_bus = pat_ad(7); cbe_bus_n = 4'h3; wr_data_done = 1;
    @(negedge clk);
    par_in = !model_par(pat_ad(7), 4'h3);
    ad_bus = pat_ad(9); cbe_bus_n = 4'h5;
    @(negedge clk);
    par_in = !model_par(pat_ad(9), 4'h5);
    wr_data_done = 0;
    check(perr_oe && !perr_n_out, "R4 first low", {perr_oe, perr_n_out}, 2'b10);
    @(negedge clk);
    par_in = 0;
    check(perr_oe && !perr_n_out, "R4 second low", {perr_oe, perr_n_out}, 2'b10);
    @(negedge clk);
    check(perr_oe && perr_n_out, "R5 high after burst", {perr_oe, perr_n_out}, 2'b11);
    @(negedge clk);
    check(!perr_oe, "R5 float after burst", perr_oe, 0);

    // R10: bad parity without qualifier is ignored
    idle(); sts_clr = 2'b11;
    @(negedge clk);
    sts_clr = 0;
    serr_en = 1;
    ad_bus = pat_ad(11);
    @(negedge clk);
    par_in = !model_par(pat_ad(11), cbe_bus_n);
    @(negedge clk);
    par_in = 0;
    check(!perr_oe && !serr_oe && sts_flags == 0, "R10 ignored",
          {perr_oe, serr_oe, sts_flags}, 0);
    @(negedge clk);
    check(!perr_oe && sts_flags == 0, "R10 ignored later", {perr_oe, sts_flags}, 0);

    // R9: set wins over same-cycle clear; zero clear keeps flags
    @(negedge clk);
    ad_bus = pat_ad(13); cbe_bus_n = 4'h9; addr_phase = 1;
    @(negedge clk);
    addr_phase = 0;
    par_in = !model_par(pat_ad(13), 4'h9);
    sts_clr = 2'b11;
    @(negedge clk);
    par_in = 0; sts_clr = 2'b00;
    check(sts_flags == 2'b11, "R9 set wins", sts_flags, 2'b11);
    @(negedge clk);
    @(negedge clk);
    check(sts_flags == 2'b11, "R9 zero clear no effect", sts_flags, 2'b11);
    sts_clr = 2'b01;
    @(negedge clk);
    sts_clr = 0;
    check(sts_flags == 2'b10, "R9 single bit clear", sts_flags, 2'b10);

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule